// File: doc/BRIEF.md
# Configurable-Frame UART Receiver

This block turns an asynchronous serial line back into bytes. A divider turns the system clock into a tick at sixteen times the bit rate. The divider value is a 16-bit run-time input. A frame sequencer driven by that tick looks for a start bit and confirms it. It then samples each following bit near the middle of its period and checks the parity bit and the stop bits against the line settings.

The line settings are shared with the matching transmitter:

- a 2-bit length code for 5 to 8 data bits;
- parity on or off;
- even or odd parity;
- a fixed (stick) parity level;
- a multiple-stop option, which means two stop bits, or one and a half stop bits in 5-bit frames.

The sequencer copies these settings when it confirms a start bit, so a frame is always decoded with the settings it began with.

Each received byte leaves on a valid/ready stream. The byte is right-aligned and zero-padded, and it carries a parity-error flag and a framing-error flag. The stream has back-pressure: data, flags and `out_valid` stay unchanged for as long as `out_ready` is low. The receiver cannot pause the serial line. If a new frame completes before the consumer takes the previous one, the newer byte replaces the older one in the output register.

Top module: `uart_frame_rx`

## Requirements
- R1: One bit period lasts 16 × `divisor` clock cycles. A `divisor` of 0 acts as 1, and a `divisor` of 1 gives a tick on every clock cycle.
- R2: `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The first received bit goes to `out_data[0]`, and every bit above the frame length reads 0.
- R3: A low level counts as a start bit only if the line is still low 8 ticks after the low was first seen. A shorter low pulse produces no output.
- R4: With `cfg_par_en`=1 and `cfg_par_fixed`=0, the bit after the last data bit is checked. With `cfg_par_even`=1, data bits plus parity bit must hold an even number of ones; with `cfg_par_even`=0, an odd number. A mismatch sets `out_par_err`.
- R5: With `cfg_par_en`=1 and `cfg_par_fixed`=1, the parity bit must equal the inverse of `cfg_par_even`. Any other level sets `out_par_err`.
- R6: With `cfg_par_en`=0, no parity bit is expected, the first stop bit follows the last data bit, and `out_par_err` is 0.
- R7: With `cfg_multi_stop`=0, one stop bit is checked. With `cfg_multi_stop`=1, a second stop is also checked. In 8-bit frames the second stop is a full bit. In 5-bit frames it is a half bit, sampled 12 ticks after the first stop sample. A low sample on any checked stop bit sets `out_frm_err`.
- R8: `out_valid` rises after a frame's last stop sample. It holds, together with `out_data` and both flags, until a cycle where `out_ready` is 1, and it drops on the following cycle.
- R9: A frame that completes while `out_valid` is still 1 replaces the held byte and flags, and `out_valid` stays 1.
- R10: Line settings are captured when the start bit is confirmed. Changing them during a frame does not affect that frame.
- R11: After reset, `out_valid`, `out_data`, `out_par_err` and `out_frm_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | DIV_W | Clock cycles per oversampling tick |
| cfg_len | input | 2 | Data length code (0..3 → 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select / fixed level select |
| cfg_par_fixed | input | 1 | Parity bit at a fixed level |
| cfg_multi_stop | input | 1 | Extra stop bit (half bit in 5-bit frames) |
| rxd | input | 1 | Serial line, idle high |
| out_ready | input | 1 | Consumer accepts the held byte |
| out_valid | output | 1 | Held byte is valid |
| out_data | output | DATA_W | Received byte, right-aligned |
| out_par_err | output | 1 | Parity mismatch for the held byte |
| out_frm_err | output | 1 | Low stop bit for the held byte |

## Verification
The bench builds the block with its default parameters: 16-bit divisor, 8-bit data path, 16× oversampling and a two-stage line synchronizer. It drives `divisor` at run time between 1 and 4. This keeps a frame to a few hundred cycles, so dozens of random frames fit in the run. A divisor of 1 exercises a tick on every cycle, where the synchronizer delay is largest compared with a bit. The 5-bit setting brings the half stop bit within reach, and the 8-bit setting brings the full second stop bit within reach. Both are checked by pulling the line low in a narrow window around the expected sample point.

// File: rtl/uart_frame_rx_pkg.sv
package uart_frame_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       par_fixed;
    logic       multi_stop;
  } line_cfg_t;

  // Level the parity bit must have, given the settings and whether the
  // received data bits hold an odd number of ones.
  function automatic logic expected_parity(input line_cfg_t c, input logic ones_odd);
    if (c.par_fixed) return ~c.par_even;
    return c.par_even ? ones_odd : ~ones_odd;
  endfunction

endpackage

// File: rtl/uart_frame_rx_tick.sv
module uart_frame_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  // A divisor of zero behaves like one.
  assign last = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/uart_frame_rx_sync.sv
module uart_frame_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_frame_rx_fsm.sv
module uart_frame_rx_fsm
  import uart_frame_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  line_cfg_t         cfg_in,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_err,
  output logic              frm_err
);
  localparam int TC_W     = $clog2(OVS);
  localparam int BI_W     = $clog2(DATA_W);
  localparam int MIN_BITS = 5;
  localparam logic [TC_W-1:0] T_HALF = TC_W'(OVS / 2 - 1);
  localparam logic [TC_W-1:0] T_FULL = TC_W'(OVS - 1);
  localparam logic [TC_W-1:0] T_3Q   = TC_W'(OVS * 3 / 4 - 1);

  rx_state_e       state;
  logic [TC_W-1:0] tcnt;
  logic [BI_W-1:0] bidx;
  logic            second_stop;
  line_cfg_t       cfg_q;
  logic [BI_W-1:0] last_idx;
  logic [TC_W-1:0] stop_lim;
  logic            par_exp;

  assign last_idx = BI_W'(MIN_BITS - 1) + BI_W'(cfg_q.len);
  // Half stop bit in 5-bit frames: sample its middle, 3/4 of a bit later.
  assign stop_lim = (second_stop && cfg_q.len == 2'd0) ? T_3Q : T_FULL;
  assign par_exp  = expected_parity(cfg_q, ^data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tcnt        <= '0;
      bidx        <= '0;
      second_stop <= 1'b0;
      cfg_q       <= '0;
      data        <= '0;
      par_err     <= 1'b0;
      frm_err     <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!rx) begin
              state <= ST_START;
              tcnt  <= '0;
            end
          end
          ST_START: begin
            if (tcnt == T_HALF) begin
              tcnt <= '0;
              if (!rx) begin
                state   <= ST_DATA;
                bidx    <= '0;
                data    <= '0;
                cfg_q   <= cfg_in;
                par_err <= 1'b0;
                frm_err <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              tcnt <= tcnt + TC_W'(1);
            end
          end
          ST_DATA: begin
            if (tcnt == T_FULL) begin
              tcnt       <= '0;
              data[bidx] <= rx;
              if (bidx == last_idx) begin
                state       <= cfg_q.par_en ? ST_PAR : ST_STOP;
                second_stop <= 1'b0;
              end else begin
                bidx <= bidx + BI_W'(1);
              end
            end else begin
              tcnt <= tcnt + TC_W'(1);
            end
          end
          ST_PAR: begin
            if (tcnt == T_FULL) begin
              tcnt    <= '0;
              par_err <= rx ^ par_exp;
              state   <= ST_STOP;
            end else begin
              tcnt <= tcnt + TC_W'(1);
            end
          end
          ST_STOP: begin
            if (tcnt == stop_lim) begin
              tcnt <= '0;
              if (!rx) frm_err <= 1'b1;
              if (!second_stop && cfg_q.multi_stop) begin
                second_stop <= 1'b1;
              end else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end else begin
              tcnt <= tcnt + TC_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_frame_rx_out.sv
module uart_frame_rx_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_par_err,
  input  logic              in_frm_err,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par_err,
  output logic              out_frm_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_par_err <= 1'b0;
      out_frm_err <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_data    <= in_data;
      out_par_err <= in_par_err;
      out_frm_err <= in_frm_err;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_frame_rx_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_fixed,
  input  logic              cfg_multi_stop,
  input  logic              rxd,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par_err,
  output logic              out_frm_err
);
  logic              tick;
  logic              rx_s;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_perr;
  logic              frm_ferr;
  line_cfg_t         cfg_now;

  assign cfg_now = '{len: cfg_len, par_en: cfg_par_en, par_even: cfg_par_even,
                     par_fixed: cfg_par_fixed, multi_stop: cfg_multi_stop};

  uart_frame_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  uart_frame_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  uart_frame_rx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s), .cfg_in(cfg_now),
    .done(frm_done), .data(frm_data), .par_err(frm_perr), .frm_err(frm_ferr)
  );

  uart_frame_rx_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(frm_done), .in_data(frm_data),
    .in_par_err(frm_perr), .in_frm_err(frm_ferr), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_par_err(out_par_err),
    .out_frm_err(out_frm_err)
  );
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIV_W-1:0]  divisor,
  input logic              tick,
  input logic              frm_done,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_par_err,
  input logic              out_frm_err
);
  // R8
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frm_done) |=>
      (out_valid && $stable(out_data) && $stable(out_par_err) && $stable(out_frm_err)));

  // R8
  release_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frm_done) |=> !out_valid);

  // R9
  load_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> out_valid);

  // R1
  unit_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor <= DIV_W'(1)) |-> tick);

  // R1
  done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_done) |-> $past(tick));
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick), .frm_done(frm_done),
  .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
  .out_par_err(out_par_err), .out_frm_err(out_frm_err)
);

// File: tb/uart_frame_rx_tb.sv
module uart_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd2;
  logic [1:0]  cfg_len = 2'd3;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_even = 1'b0;
  logic        cfg_par_fixed = 1'b0;
  logic        cfg_multi_stop = 1'b0;
  logic        rxd = 1'b1;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_par_err;
  logic        out_frm_err;

  int checks = 0;
  int errors = 0;
  int div = 2;

  always #10 clk = ~clk;

  uart_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_par_fixed(cfg_par_fixed),
    .cfg_multi_stop(cfg_multi_stop), .rxd(rxd), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_par_err(out_par_err),
    .out_frm_err(out_frm_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_data(input logic [7:0] b, input int nb);
    return b & 8'((1 << nb) - 1);
  endfunction

  function automatic logic par_bit(input logic [7:0] b, input int nb, input logic ev, input logic fx);
    logic [7:0] m = mask_data(b, nb);
    int ones = $countones(m);
    if (fx) return !ev;
    if (ev) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  task automatic drive(input logic v, input int ticks);
    rxd = v;
    repeat (ticks * div) @(posedge clk);
    #1;
  endtask

  // bad_stop: 0 none, 1 first stop pulled low, 2 extra stop pulled low
  task automatic send_frame(input logic [7:0] b, input int len, input logic pe, input logic ev,
                            input logic fx, input logic ms, input logic flip,
                            input int bad_stop, input logic mid_change);
    int nb = 5 + len;
    logic p;
    cfg_len = 2'(len); cfg_par_en = pe; cfg_par_even = ev; cfg_par_fixed = fx; cfg_multi_stop = ms;
    drive(1'b0, 16);
    if (mid_change) begin
      cfg_len = ~cfg_len; cfg_par_en = ~pe; cfg_par_even = ~ev; cfg_multi_stop = ~ms;
    end
    for (int i = 0; i < nb; i++) drive(b[i], 16);
    if (pe) begin
      p = par_bit(b, nb, ev, fx) ^ flip;
      drive(p, 16);
    end
    if (bad_stop == 1) begin drive(1, 4); drive(0, 8); drive(1, 4); end
    else drive(1, 16);
    if (ms) begin
      if (nb == 5) begin
        if (bad_stop == 2) begin drive(1, 2); drive(0, 4); drive(1, 2); end
        else drive(1, 8);
      end else begin
        if (bad_stop == 2) begin drive(1, 4); drive(0, 8); drive(1, 4); end
        else drive(1, 16);
      end
    end
    cfg_len = 2'(len); cfg_par_en = pe; cfg_par_even = ev; cfg_par_fixed = fx; cfg_multi_stop = ms;
    drive(1, 16);
  endtask

  task automatic expect_byte(input string req, input logic [7:0] b, input int len,
                             input logic pe, input logic flip, input logic ms, input int bad_stop);
    @(negedge clk);
    check({req, " valid"}, out_valid, 1);
    check({req, " data"}, out_data, mask_data(b, 5 + len));
    check({req, " parity err"}, out_par_err, pe && flip);
    check({req, " framing err"}, out_frm_err, (bad_stop == 1) || (bad_stop == 2 && ms));
  endtask

  task automatic consume(input string req);
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check({req, " valid drops after ready"}, out_valid, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 valid", out_valid, 0);
    check("R11 data", out_data, 0);
    check("R11 perr", out_par_err, 0);
    check("R11 ferr", out_frm_err, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    drive(1, 20);

    // R2 R6 8-bit, no parity, divisor 2
    div = 2; divisor = 16'd2;
    send_frame(8'hA5, 3, 0, 0, 0, 0, 0, 0, 0);
    expect_byte("R2 R6 8N1", 8'hA5, 3, 0, 0, 0, 0);
    // R8 hold while out_ready low
    drive(1, 32);
    @(negedge clk);
    check("R8 held valid", out_valid, 1);
    check("R8 held data", out_data, 8'hA5);
    consume("R8");

    // R2 5-bit zero padding
    send_frame(8'hFF, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_byte("R2 5-bit pad", 8'hFF, 0, 0, 0, 0, 0);
    consume("R2");

    // R4 even and odd computed parity, good and bad
    send_frame(8'h37, 3, 1, 1, 0, 0, 0, 0, 0);
    expect_byte("R4 even ok", 8'h37, 3, 1, 0, 0, 0); consume("R4");
    send_frame(8'h37, 3, 1, 1, 0, 0, 1, 0, 0);
    expect_byte("R4 even bad", 8'h37, 3, 1, 1, 0, 0); consume("R4");
    send_frame(8'h2C, 2, 1, 0, 0, 0, 1, 0, 0);
    expect_byte("R4 odd bad", 8'h2C, 2, 1, 1, 0, 0); consume("R4");

    // R5 fixed parity levels
    send_frame(8'h11, 1, 1, 1, 1, 0, 0, 0, 0);
    expect_byte("R5 fixed 0 ok", 8'h11, 1, 1, 0, 0, 0); consume("R5");
    send_frame(8'h11, 1, 1, 0, 1, 0, 1, 0, 0);
    expect_byte("R5 fixed 1 bad", 8'h11, 1, 1, 1, 0, 0); consume("R5");

    // R7 stop bits: first low, extra full stop low, extra half stop low
    div = 3; divisor = 16'd3;
    send_frame(8'h5A, 3, 0, 0, 0, 0, 0, 1, 0);
    expect_byte("R7 first stop low", 8'h5A, 3, 0, 0, 0, 1); consume("R7");
    send_frame(8'h5A, 3, 1, 1, 0, 1, 0, 2, 0);
    expect_byte("R7 second stop low", 8'h5A, 3, 1, 0, 1, 2); consume("R7");
    send_frame(8'h15, 0, 0, 0, 0, 1, 0, 2, 0);
    expect_byte("R7 half stop low", 8'h15, 0, 0, 0, 1, 2); consume("R7");
    send_frame(8'h0A, 0, 1, 0, 0, 1, 0, 0, 0);
    expect_byte("R7 1.5 stop ok", 8'h0A, 0, 1, 0, 1, 0); consume("R7");

    // R3 short low pulse ignored
    drive(0, 3);
    drive(1, 48);
    @(negedge clk);
    check("R3 glitch ignored", out_valid, 0);

    // R10 settings changed mid-frame
    send_frame(8'hC3, 3, 1, 1, 0, 1, 0, 0, 1);
    expect_byte("R10 captured cfg", 8'hC3, 3, 1, 0, 1, 0); consume("R10");

    // R9 overwrite without consume
    send_frame(8'h12, 3, 0, 0, 0, 0, 0, 0, 0);
    send_frame(8'h34, 3, 1, 0, 0, 0, 1, 0, 0);
    expect_byte("R9 overwrite", 8'h34, 3, 1, 1, 0, 0); consume("R9");

    // R1 divisor 1 and random frames over divisors 1..4
    for (int n = 0; n < 30; n++) begin
      logic [7:0] b = 8'($urandom);
      int len = int'($urandom % 4);
      logic pe = 1'($urandom);
      logic ev = 1'($urandom);
      logic fx = 1'($urandom);
      logic ms = 1'($urandom);
      logic fl = pe & 1'($urandom);
      div = (n < 3) ? 1 : 1 + int'($urandom % 4);
      divisor = 16'(div);
      send_frame(b, len, pe, ev, fx, ms, fl, 0, 0);
      expect_byte("R1 random", b, len, pe, fl, ms, 0);
      consume("R1");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule